// File: doc/BRIEF.md
# Triggered Dual-Array Frame Assembler

This block turns one qualified trigger into one fixed-length frame of 16-bit words and writes it into a downstream FIFO. The trigger line is synchronised and must stay high for a minimum number of clock cycles before it counts. An accepted trigger starts a fixed sequence of steps. First come a sync word and a running frame counter. Next the block reads the two sensor arrays one pixel index at a time, and each index returns a lower and an upper value together. After the last pixel it takes one conversion of the two auxiliary ADC channels. Then come four digital levels, each widened to a full word, and finally two spare words supplied by the host side.

The sensor arrays and ADCs are modelled as request/valid handshakes. Each request is held until its valid strobe arrives. The FIFO write port honours a full flag: while full is high, no word is written and none is lost. No new frame can start until the last word of the current frame has been written. With default parameters the frame is 522 words long (2·PIX_COUNT + 10).

Top module: `pixframe_asm`

## Requirements
- R1: A rising trigger starts a frame only if, after synchronisation, it stays high for at least QUAL_CYCLES consecutive clocks (the count sized to 250 ns). Shorter pulses start nothing, and one high level starts at most one frame.
- R2: A trigger that qualifies while trig_en is low starts no frame and writes no word.
- R3: A frame is exactly 2·PIX_COUNT+10 words long, and its first word is the sync constant 0xA5A5.
- R4: The second word is a frame counter. It is 0xFC00 in the first frame after reset and rises by one (modulo 2^16) in each later frame.
- R5: Pixel indices are read in rising order from 0, with pix_req held until pix_vld. Word 3+2n is the lower value of index n and word 4+2n is the upper value.
- R6: ana_req is raised only after the last pixel pair has been received. The next two words are auxiliary B and then auxiliary A.
- R7: The four words after the auxiliary words carry dig_in[0] to dig_in[3] in that order. Each word is 0xFFFF when its bit is 1 and 0x0000 when it is 0. The levels are taken when auxiliary word B is written.
- R8: The last two words are spare_a and then spare_b, as presented when each is written.
- R9: A trigger that qualifies while busy is high is ignored. It does not extend, restart or follow the running frame.
- R10: fifo_wr is never high while fifo_full is high. A stalled frame still arrives complete, in order and without duplicates.
- R11: test_mode is latched when a frame starts. If it is set, pixel word k (counted from 0 within the pixel region) carries the value k, and all other words and all handshakes are unchanged.
- R12: busy, fifo_wr, pix_req and ana_req are low after reset. busy is high from the accepted trigger until the final word is written, and no write occurs while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous trigger line |
| trig_en | input | 1 | Allows qualified triggers to start frames |
| test_mode | input | 1 | Replaces pixel words by a counting pattern |
| pix_req | output | 1 | Requests the next pixel pair |
| pix_vld | input | 1 | Pixel pair valid strobe |
| pix_lo | input | 16 | Lower array value |
| pix_hi | input | 16 | Upper array value |
| ana_req | output | 1 | Requests one auxiliary conversion |
| ana_vld | input | 1 | Auxiliary results valid strobe |
| ana_a | input | 16 | Auxiliary channel A result |
| ana_b | input | 16 | Auxiliary channel B result |
| dig_in | input | 4 | Digital levels |
| spare_a | input | 16 | First spare word |
| spare_b | input | 16 | Second spare word |
| fifo_full | input | 1 | Downstream FIFO cannot accept a word |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 16 | FIFO write data |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the block with PIX_COUNT=4 and QUAL_CYCLES=3. Each frame is then 18 words long, so many frames fit in a short run, including ones stalled by a toggling full flag and ones in test mode. The short qualification window puts the reject/accept edge between 2-cycle and 3-cycle pulses within easy reach. Triggers can also be fired in the middle of a short frame to check that they are ignored.

// File: rtl/pfa_pkg.sv
`timescale 1ns/1ps
package pfa_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SYNC, ST_CNT, ST_PREQ, ST_PLO, ST_PHI,
    ST_AREQ, ST_AB, ST_AA, ST_DIG, ST_SPA, ST_SPB
  } st_e;
endpackage

// File: rtl/pfa_trig_qual.sv
`timescale 1ns/1ps
module pfa_trig_qual #(
  parameter int QUAL_CYCLES = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  output logic trig_ok
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   lvl;

  assign lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      run_q   <= '0;
      trig_ok <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], trig_in};
      if (!lvl)
        run_q <= '0;
      else if (run_q != CW'(QUAL_CYCLES))
        run_q <= run_q + 1'b1;
      trig_ok <= lvl && (run_q == CW'(QUAL_CYCLES - 1));
    end
  end
endmodule

// File: rtl/pfa_seq.sv
`timescale 1ns/1ps
module pfa_seq
  import pfa_pkg::*;
#(
  parameter int PIX_COUNT = 256,
  parameter int DIG_COUNT = 4,
  localparam int PW = $clog2(PIX_COUNT),
  localparam int DW = $clog2(DIG_COUNT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig_ok,
  input  logic          trig_en,
  input  logic          pix_vld,
  input  logic          ana_vld,
  input  logic          fifo_full,
  output st_e           st,
  output logic [PW-1:0] pix_idx,
  output logic [DW-1:0] dig_idx,
  output logic          start,
  output logic          wr
);
  st_e st_q, st_d;
  logic emit;

  assign st    = st_q;
  assign start = trig_ok && trig_en && (st_q == ST_IDLE);

  always_comb begin
    unique case (st_q)
      ST_SYNC, ST_CNT, ST_PLO, ST_PHI, ST_AB, ST_AA,
      ST_DIG, ST_SPA, ST_SPB: emit = 1'b1;
      default:                emit = 1'b0;
    endcase
  end

  assign wr = emit && !fifo_full;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start)   st_d = ST_SYNC;
      ST_SYNC: if (wr)      st_d = ST_CNT;
      ST_CNT:  if (wr)      st_d = ST_PREQ;
      ST_PREQ: if (pix_vld) st_d = ST_PLO;
      ST_PLO:  if (wr)      st_d = ST_PHI;
      ST_PHI:  if (wr)      st_d = (pix_idx == PW'(PIX_COUNT - 1)) ? ST_AREQ : ST_PREQ;
      ST_AREQ: if (ana_vld) st_d = ST_AB;
      ST_AB:   if (wr)      st_d = ST_AA;
      ST_AA:   if (wr)      st_d = ST_DIG;
      ST_DIG:  if (wr && dig_idx == DW'(DIG_COUNT - 1)) st_d = ST_SPA;
      ST_SPA:  if (wr)      st_d = ST_SPB;
      ST_SPB:  if (wr)      st_d = ST_IDLE;
      default:              st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      pix_idx <= '0;
      dig_idx <= '0;
    end else begin
      st_q <= st_d;
      if (start)
        pix_idx <= '0;
      else if (st_q == ST_PHI && wr)
        pix_idx <= pix_idx + 1'b1;
      if (st_q == ST_AA && wr)
        dig_idx <= '0;
      else if (st_q == ST_DIG && wr)
        dig_idx <= dig_idx + 1'b1;
    end
  end
endmodule

// File: rtl/pfa_word_sel.sv
`timescale 1ns/1ps
module pfa_word_sel
  import pfa_pkg::*;
#(
  parameter int                PIX_COUNT = 256,
  parameter int                DIG_COUNT = 4,
  parameter int                DATA_W    = 16,
  parameter logic [DATA_W-1:0] SYNC_WORD = 'hA5A5,
  parameter logic [DATA_W-1:0] CNT_SEED  = 'hFC00,
  localparam int PW = $clog2(PIX_COUNT),
  localparam int DW = $clog2(DIG_COUNT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  st_e                  st,
  input  logic [PW-1:0]        pix_idx,
  input  logic [DW-1:0]        dig_idx,
  input  logic                 start,
  input  logic                 wr,
  input  logic                 test_mode,
  input  logic                 pix_vld,
  input  logic [DATA_W-1:0]    pix_lo,
  input  logic [DATA_W-1:0]    pix_hi,
  input  logic                 ana_vld,
  input  logic [DATA_W-1:0]    ana_a,
  input  logic [DATA_W-1:0]    ana_b,
  input  logic [DIG_COUNT-1:0] dig_in,
  input  logic [DATA_W-1:0]    spare_a,
  input  logic [DATA_W-1:0]    spare_b,
  output logic [DATA_W-1:0]    word
);
  logic                 tm_q;
  logic [DATA_W-1:0]    lo_q, hi_q, a_q, b_q, cnt_q;
  logic [DIG_COUNT-1:0] dig_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tm_q  <= 1'b0;
      lo_q  <= '0;
      hi_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      dig_q <= '0;
      cnt_q <= CNT_SEED;
    end else begin
      if (start) tm_q <= test_mode;
      if (st == ST_PREQ && pix_vld) begin
        lo_q <= pix_lo;
        hi_q <= pix_hi;
      end
      if (st == ST_AREQ && ana_vld) begin
        a_q <= ana_a;
        b_q <= ana_b;
      end
      if (st == ST_AB && wr) dig_q <= dig_in;
      if (st == ST_CNT && wr) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    unique case (st)
      ST_SYNC: word = SYNC_WORD;
      ST_CNT:  word = cnt_q;
      ST_PLO:  word = tm_q ? DATA_W'({pix_idx, 1'b0}) : lo_q;
      ST_PHI:  word = tm_q ? DATA_W'({pix_idx, 1'b1}) : hi_q;
      ST_AB:   word = b_q;
      ST_AA:   word = a_q;
      ST_DIG:  word = {DATA_W{dig_q[dig_idx]}};
      ST_SPA:  word = spare_a;
      ST_SPB:  word = spare_b;
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/pixframe_asm.sv
`timescale 1ns/1ps
module pixframe_asm
  import pfa_pkg::*;
#(
  parameter int                PIX_COUNT   = 256,
  parameter int                DIG_COUNT   = 4,
  parameter int                DATA_W      = 16,
  parameter int                QUAL_CYCLES = 25,
  parameter logic [DATA_W-1:0] SYNC_WORD   = 'hA5A5,
  parameter logic [DATA_W-1:0] CNT_SEED    = 'hFC00
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 trig_in,
  input  logic                 trig_en,
  input  logic                 test_mode,
  output logic                 pix_req,
  input  logic                 pix_vld,
  input  logic [DATA_W-1:0]    pix_lo,
  input  logic [DATA_W-1:0]    pix_hi,
  output logic                 ana_req,
  input  logic                 ana_vld,
  input  logic [DATA_W-1:0]    ana_a,
  input  logic [DATA_W-1:0]    ana_b,
  input  logic [DIG_COUNT-1:0] dig_in,
  input  logic [DATA_W-1:0]    spare_a,
  input  logic [DATA_W-1:0]    spare_b,
  input  logic                 fifo_full,
  output logic                 fifo_wr,
  output logic [DATA_W-1:0]    fifo_data,
  output logic                 busy
);
  localparam int PW = $clog2(PIX_COUNT);
  localparam int DW = $clog2(DIG_COUNT);

  logic          trig_ok, start, wr;
  st_e           st;
  logic [PW-1:0] pix_idx;
  logic [DW-1:0] dig_idx;

  pfa_trig_qual #(.QUAL_CYCLES(QUAL_CYCLES), .SYNC_STAGES(2)) u_qual (
    .clk(clk), .rst(rst), .trig_in(trig_in), .trig_ok(trig_ok)
  );

  pfa_seq #(.PIX_COUNT(PIX_COUNT), .DIG_COUNT(DIG_COUNT)) u_seq (
    .clk(clk), .rst(rst), .trig_ok(trig_ok), .trig_en(trig_en),
    .pix_vld(pix_vld), .ana_vld(ana_vld), .fifo_full(fifo_full),
    .st(st), .pix_idx(pix_idx), .dig_idx(dig_idx), .start(start), .wr(wr)
  );

  pfa_word_sel #(
    .PIX_COUNT(PIX_COUNT), .DIG_COUNT(DIG_COUNT), .DATA_W(DATA_W),
    .SYNC_WORD(SYNC_WORD), .CNT_SEED(CNT_SEED)
  ) u_word (
    .clk(clk), .rst(rst), .st(st), .pix_idx(pix_idx), .dig_idx(dig_idx),
    .start(start), .wr(wr), .test_mode(test_mode),
    .pix_vld(pix_vld), .pix_lo(pix_lo), .pix_hi(pix_hi),
    .ana_vld(ana_vld), .ana_a(ana_a), .ana_b(ana_b), .dig_in(dig_in),
    .spare_a(spare_a), .spare_b(spare_b), .word(fifo_data)
  );

  assign fifo_wr = wr;
  assign busy    = (st != ST_IDLE);
  assign pix_req = (st == ST_PREQ);
  assign ana_req = (st == ST_AREQ);
endmodule

// File: rtl/pixframe_asm_chk.sv
`timescale 1ns/1ps
module pixframe_asm_chk #(
  parameter int                DATA_W    = 16,
  parameter logic [DATA_W-1:0] SYNC_WORD = 'hA5A5
) (
  input logic              clk,
  input logic              rst,
  input logic              fifo_full,
  input logic              fifo_wr,
  input logic [DATA_W-1:0] fifo_data,
  input logic              busy,
  input logic              pix_req,
  input logic              pix_vld,
  input logic              ana_req
);
  a_r10_no_write_full: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !fifo_wr);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!fifo_wr && !pix_req && !ana_req));

  a_r12_last_word: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(fifo_wr));

  a_r3_sync_first: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && !fifo_full) |-> (fifo_wr && fifo_data == SYNC_WORD));

  a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
    (pix_req && !pix_vld) |=> pix_req);

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(pix_req && ana_req));
endmodule

bind pixframe_asm pixframe_asm_chk #(.DATA_W(DATA_W), .SYNC_WORD(SYNC_WORD)) u_chk (
  .clk(clk), .rst(rst), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
  .fifo_data(fifo_data), .busy(busy), .pix_req(pix_req), .pix_vld(pix_vld),
  .ana_req(ana_req)
);

// File: tb/pixframe_asm_bench.sv
`timescale 1ns/1ps
module pixframe_asm_bench;
  localparam int PIX  = 4;
  localparam int QUAL = 3;
  localparam int FLEN = 2*PIX + 10;

  typedef struct packed {
    logic        tm;
    logic        stall;
    logic [3:0]  dig;
    logic [15:0] sa, sb, aa, ab, base;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{1'b0, 1'b0, 4'b1010, 16'h1234, 16'h5678, 16'h0AAA, 16'h0BBB, 16'h2000},
    '{1'b0, 1'b1, 4'b0101, 16'hCAFE, 16'hBEEF, 16'h7001, 16'h8002, 16'h3100},
    '{1'b1, 1'b0, 4'b1111, 16'h0001, 16'hFFFE, 16'h4444, 16'h5555, 16'h6000},
    '{1'b1, 1'b1, 4'b0000, 16'h9999, 16'h0000, 16'hA0A0, 16'h0B0B, 16'h7700}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, trig_in = 1'b0, trig_en = 1'b1, test_mode = 1'b0;
  logic pix_req, pix_vld = 1'b0, ana_req, ana_vld = 1'b0;
  logic [15:0] pix_lo = '0, pix_hi = '0, ana_a = '0, ana_b = '0;
  logic [3:0]  dig_in = '0;
  logic [15:0] spare_a = '0, spare_b = '0;
  logic fifo_full = 1'b0, fifo_wr, busy;
  logic [15:0] fifo_data;

  pixframe_asm #(.PIX_COUNT(PIX), .QUAL_CYCLES(QUAL)) u_pixframe_asm (
    .clk(clk), .rst(rst), .trig_in(trig_in), .trig_en(trig_en), .test_mode(test_mode),
    .pix_req(pix_req), .pix_vld(pix_vld), .pix_lo(pix_lo), .pix_hi(pix_hi),
    .ana_req(ana_req), .ana_vld(ana_vld), .ana_a(ana_a), .ana_b(ana_b),
    .dig_in(dig_in), .spare_a(spare_a), .spare_b(spare_b),
    .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_data(fifo_data), .busy(busy)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, wcnt = 0, pix_n = 0, pix_at_ana = -1;
  logic [15:0] got [64];
  logic [15:0] expw [64];
  logic [15:0] base_v = '0, aa_v = '0, ab_v = '0, exp_cnt = 16'hFC00;
  logic stall_en = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // output monitor: sample 1 ns before each rising edge
  initial forever begin
    @(posedge clk); #19;
    cyc++;
    if (fifo_wr) begin
      if (wcnt < 64) got[wcnt] = fifo_data;
      wcnt++;
    end
  end

  // handshake responders and FIFO backpressure, driven on falling edges
  initial forever begin
    @(negedge clk);
    if (pix_req && !pix_vld) begin
      pix_vld = 1'b1;
      pix_lo  = base_v + 16'(pix_n);
      pix_hi  = base_v + 16'h1000 + 16'(pix_n);
      pix_n++;
    end else pix_vld = 1'b0;
    if (ana_req && !ana_vld) begin
      ana_vld = 1'b1;
      ana_a = aa_v;
      ana_b = ab_v;
      pix_at_ana = pix_n;
    end else ana_vld = 1'b0;
    fifo_full = stall_en && (cyc % 3 == 1);
  end

  task automatic pulse(input int len);
    @(negedge clk); trig_in = 1'b1;
    repeat (len) @(negedge clk);
    trig_in = 1'b0;
  endtask

  task automatic wait_busy(output bit seen);
    seen = 1'b0;
    for (int t = 0; t < 40 && !seen; t++) begin
      if (busy) seen = 1'b1; else @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 5000 && busy; t++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic cmp(input int lo, input int hi, input string tag);
    int bad_i = -1;
    for (int k = lo; k <= hi; k++)
      if (bad_i < 0 && got[k] !== expw[k]) bad_i = k;
    if (bad_i < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, $sformatf("%s word%0d", tag, bad_i + 1), got[bad_i], expw[bad_i]);
  endtask

  task automatic run_frame(input vec_t v, input int plen, input string tag);
    bit seen;
    test_mode = v.tm; stall_en = v.stall; dig_in = v.dig;
    spare_a = v.sa; spare_b = v.sb; aa_v = v.aa; ab_v = v.ab; base_v = v.base;
    wcnt = 0; pix_n = 0; pix_at_ana = -1;
    pulse(plen);
    wait_busy(seen);
    chk(seen, {tag, " R1 frame start"}, 32'(seen), 1);
    wait_idle();
    stall_en = 1'b0;
    expw[0] = 16'hA5A5;
    expw[1] = exp_cnt;
    for (int n = 0; n < PIX; n++) begin
      expw[2+2*n] = v.tm ? 16'(2*n)   : v.base + 16'(n);
      expw[3+2*n] = v.tm ? 16'(2*n+1) : v.base + 16'h1000 + 16'(n);
    end
    expw[2+2*PIX] = v.ab;
    expw[3+2*PIX] = v.aa;
    for (int i = 0; i < 4; i++) expw[4+2*PIX+i] = v.dig[i] ? 16'hFFFF : 16'h0000;
    expw[8+2*PIX] = v.sa;
    expw[9+2*PIX] = v.sb;
    chk(wcnt == FLEN, {tag, (v.stall ? " R10" : ""), " R3 length"}, 32'(wcnt), FLEN);
    cmp(0, 0, {tag, " R3 sync"});
    cmp(1, 1, {tag, " R4 counter"});
    cmp(2, 1+2*PIX, {tag, (v.tm ? " R11" : " R5"), " pixels"});
    cmp(2+2*PIX, 3+2*PIX, {tag, " R6 aux B,A"});
    chk(pix_at_ana == PIX, {tag, " R6 aux after pixels"}, 32'(pix_at_ana), PIX);
    cmp(4+2*PIX, 7+2*PIX, {tag, " R7 digital"});
    cmp(8+2*PIX, 9+2*PIX, {tag, " R8 spare"});
    chk(!busy, {tag, " R12 busy low at end"}, 32'(busy), 0);
    exp_cnt++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R12 actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit seen;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(!busy,    "R12 reset busy",    32'(busy), 0);
    chk(!fifo_wr, "R12 reset fifo_wr", 32'(fifo_wr), 0);
    chk(!pix_req && !ana_req, "R12 reset requests", 32'({pix_req, ana_req}), 0);

    // vector table walk
    for (int i = 0; i < 4; i++) run_frame(VEC[i], 6, $sformatf("vec%0d", i));

    // R1: 2-cycle pulse is rejected, 3-cycle pulse is accepted
    wcnt = 0;
    pulse(QUAL - 1);
    repeat (20) @(negedge clk);
    chk(!busy && wcnt == 0, "R1 short pulse rejected", 32'(wcnt), 0);
    run_frame(VEC[0], QUAL, "R1 minimum pulse");

    // R2: trigger disabled
    trig_en = 1'b0; wcnt = 0;
    pulse(8);
    repeat (20) @(negedge clk);
    chk(!busy && wcnt == 0, "R2 disabled trigger", 32'(wcnt), 0);
    trig_en = 1'b1;

    // R9: trigger during a running frame
    wcnt = 0; pix_n = 0; base_v = 16'h4000;
    pulse(6);
    wait_busy(seen);
    repeat (4) @(negedge clk);
    pulse(6);
    chk(busy, "R9 frame still running at retrigger", 32'(busy), 1);
    wait_idle();
    exp_cnt++;
    repeat (30) @(negedge clk);
    chk(!busy && wcnt == FLEN, "R9 retrigger ignored", 32'(wcnt), FLEN);

    // R4: counter continues after ignored and rejected triggers
    run_frame(VEC[1], 6, "R4 counter continuity");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule